// File: doc/BRIEF.md
# UART Interrupt Priority Resolver

This block is the interrupt identification stage of a 16550-style serial port. It collects every cause that can interrupt the host and ranks them: line errors, a receive character timeout, receive data at or above the trigger level, an empty transmit holding register, and modem-line changes. It then presents the winner as an identification byte and drives one interrupt request line. It owns three pieces of state: the four-bit interrupt enable register, the line status byte, and the transmit-empty pending flag. The register-access side effects that belong to them are handled here as well.

The serial shifters, FIFO storage, baud timing and modem-line sampling all sit outside the block. They report to it through single-cycle event pulses (byte received, break, overrun, parity, framing, receive drained, transmit register written, holding register drained, shifter idle) and through level inputs (FIFO mode, receive count, trigger level, timeout pending, modem deltas). The host reaches the block through a register port with addresses 1 (enable), 2 (identification) and 5 (line status). Read data comes back in the same cycle. Read side effects take place at the clock edge that ends the read cycle.

The transmit-empty pending flag is a two-state machine. THR_QUIET moves to THR_ARMED on the transition *drain*, when the holding register empties, or on *rearm*, when the enable bit for that cause changes to 1 while the holding register is empty. THR_ARMED moves back to THR_QUIET on *load*, a host write to the holding register; on *disarm*, when the enable bit changes to 0; or on *ack*, a read of the identification register while it shows the transmit-empty code. In either state, when nothing applies, the transition *hold* keeps the state. When several events arrive together, the order is load, then enable change, then ack, then drain.

Top module: `uart_irq_resolver`

## Requirements
- R1: Causes are ranked from highest to lowest as line status (code 0x6), character timeout (0xC), receive data (0x4), transmit empty (0x2) and modem status (0x0). The code sits in identification bits 3:0. The value 0x1 in those bits means nothing is pending.
- R2: The line status cause is active when enable bit 2 is set and any of line status bits 4:1 (break, framing, parity, overrun) is set.
- R3: The character timeout cause is reported only while enable bit 0 (receive data) is set. With that bit clear, neither timeout nor receive data is reported.
- R4: In FIFO mode the receive data cause needs data ready (line status bit 0) and a receive count at or above the trigger level. Outside FIFO mode, data ready alone is enough.
- R5: A read of the identification register while it shows 0x2 clears the transmit-empty pending flag from the next cycle on.
- R6: When enable bit 1 changes, the pending flag becomes 1 if the bit is now 1 and line status bit 5 (holding empty) is 1, and 0 otherwise.
- R7: A line status read returns the value held before the read and then clears bits 4 (break) and 1 (overrun). Bits 0, 2 and 3 are kept. A receive-drained pulse clears bits 0, 2, 3 and 4.
- R8: An enable register write keeps only bits 3:0. A read returns them with bits 7:4 as zero.
- R9: Identification bits 7:6 read 11 in FIFO mode and 00 otherwise. The interrupt line is high exactly when the code is not 0x1, including for modem code 0x0.
- R10: After reset the enable register reads 0x00, identification reads 0x01 (FIFO mode off) and line status reads 0x60.
- R11: A holding-register write clears line status bits 5 and 6 and the pending flag. A holding-drained pulse sets bit 5 and the pending flag. A shifter-idle pulse sets bit 6.
- R12: A change on a level input (receive count, trigger level, timeout, modem deltas, FIFO mode) shows in the identification value and the interrupt line in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, same cycle |
| fifo_en | input | 1 | FIFO mode active |
| rx_count | input | CNT_W | Bytes in the receive FIFO |
| rx_trig | input | CNT_W | Receive trigger level |
| timeout_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status delta bits |
| rx_push | input | 1 | Byte received (sets data ready) |
| rx_brk | input | 1 | Break received (sets break and data ready) |
| rx_ovr | input | 1 | Receive overrun |
| rx_par | input | 1 | Parity error |
| rx_frm | input | 1 | Framing error |
| rx_drained | input | 1 | Receive side emptied |
| thr_wr | input | 1 | Holding register written |
| thr_drained | input | 1 | Holding register emptied |
| tx_idle | input | 1 | Transmit shifter idle |
| iir | output | 8 | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
A pending flag stuck in the wrong state shows at the first identification read after that state is entered: a stale 0x2 either appears or is missing. Reading 0x2 a second time exposes an acknowledge that failed to clear the flag. A wrong line status bit shows on the next status read. A bit that the read should have cleared shows on the read after that. A bad priority or mask term shows in the same cycle as the cause, both on the interrupt line and in the identification value. The sequences therefore stack causes and then peel them away one at a time.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IID_MODEM  = 4'h0,
        IID_NONE   = 4'h1,
        IID_THR    = 4'h2,
        IID_RXDATA = 4'h4,
        IID_LINE   = 4'h6,
        IID_TMO    = 4'hC
    } iid_e;

    typedef enum logic {
        THR_QUIET = 1'b0,
        THR_ARMED = 1'b1
    } thr_st_e;

    localparam logic [2:0] ADDR_IER = 3'd1;
    localparam logic [2:0] ADDR_IIR = 3'd2;
    localparam logic [2:0] ADDR_LSR = 3'd5;

    localparam int EN_RX   = 0;
    localparam int EN_THR  = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;

    localparam int LS_DR   = 0;
    localparam int LS_OE   = 1;
    localparam int LS_PE   = 2;
    localparam int LS_FE   = 3;
    localparam int LS_BI   = 4;
    localparam int LS_THRE = 5;
    localparam int LS_TEMT = 6;

    localparam logic [7:0] LSR_RESET = 8'h60;

endpackage

// File: rtl/uart_irq_lsr.sv
`timescale 1ns/1ps
module uart_irq_lsr
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_push,
    input  logic       rx_brk,
    input  logic       rx_ovr,
    input  logic       rx_par,
    input  logic       rx_frm,
    input  logic       rx_drained,
    input  logic       thr_wr,
    input  logic       thr_drained,
    input  logic       tx_idle,
    input  logic       lsr_rd,
    output logic [7:0] lsr_q
);

    logic [7:0] lsr_d;

    always_comb begin
        lsr_d = lsr_q;
        // receive side
        if (rx_push || rx_brk)       lsr_d[LS_DR] = 1'b1;
        else if (rx_drained)         lsr_d[LS_DR] = 1'b0;
        if (rx_brk)                  lsr_d[LS_BI] = 1'b1;
        else if (lsr_rd || rx_drained) lsr_d[LS_BI] = 1'b0;
        if (rx_ovr)                  lsr_d[LS_OE] = 1'b1;
        else if (lsr_rd)             lsr_d[LS_OE] = 1'b0;
        if (rx_par)                  lsr_d[LS_PE] = 1'b1;
        else if (rx_drained)         lsr_d[LS_PE] = 1'b0;
        if (rx_frm)                  lsr_d[LS_FE] = 1'b1;
        else if (rx_drained)         lsr_d[LS_FE] = 1'b0;
        // transmit side
        if (thr_wr)                  lsr_d[LS_THRE] = 1'b0;
        else if (thr_drained)        lsr_d[LS_THRE] = 1'b1;
        if (thr_wr)                  lsr_d[LS_TEMT] = 1'b0;
        else if (tx_idle)            lsr_d[LS_TEMT] = 1'b1;
        lsr_d[7] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lsr_q <= LSR_RESET;
        else        lsr_q <= lsr_d;
    end

    // R7: a status read clears break and overrun unless re-set in that cycle
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !rx_brk && !rx_ovr) |=> (!lsr_q[LS_BI] && !lsr_q[LS_OE]));

    // R11: a holding-register write empties neither flag afterwards
    a_r11_thr_load: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (!lsr_q[LS_THRE] && !lsr_q[LS_TEMT]));

endmodule

// File: rtl/uart_irq_thr_fsm.sv
`timescale 1ns/1ps
module uart_irq_thr_fsm
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ier_wr,
    input  logic [3:0] ier_wdata,
    input  logic       thr_wr,
    input  logic       thr_drained,
    input  logic       thre,
    input  logic       iir_ack,
    output logic [3:0] ier_q,
    output logic       thr_pend
);

    thr_st_e state_q, state_d;
    logic    en_toggle;

    assign en_toggle = ier_wr && (ier_wdata[EN_THR] != ier_q[EN_THR]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= THR_QUIET;
            ier_q   <= 4'h0;
        end else begin
            state_q <= state_d;
            if (ier_wr) ier_q <= ier_wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THR_QUIET: begin
                if (thr_wr)                              state_d = THR_QUIET; // load
                else if (en_toggle)                      state_d = (ier_wdata[EN_THR] && thre)
                                                                   ? THR_ARMED : THR_QUIET; // rearm
                else if (thr_drained)                    state_d = THR_ARMED; // drain
                else                                     state_d = THR_QUIET; // hold
            end
            THR_ARMED: begin
                if (thr_wr)                              state_d = THR_QUIET; // load
                else if (en_toggle)                      state_d = (ier_wdata[EN_THR] && thre)
                                                                   ? THR_ARMED : THR_QUIET; // disarm/rearm
                else if (iir_ack)                        state_d = THR_QUIET; // ack
                else                                     state_d = THR_ARMED; // hold
            end
            default:                                     state_d = THR_QUIET;
        endcase
    end

    always_comb thr_pend = (state_q == THR_ARMED);

    // R6: turning the transmit-empty enable on while empty arms the flag
    a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (en_toggle && ier_wdata[EN_THR] && thre && !thr_wr) |=> thr_pend);

    // R5: acknowledging through the identification read drops the flag
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_ack && !thr_wr && !thr_drained && !en_toggle) |=> !thr_pend);

    // R8: the enable register takes the written low nibble
    a_r8_ier_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> (ier_q == $past(ier_wdata)));

endmodule

// File: rtl/uart_irq_prio.sv
`timescale 1ns/1ps
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       ier,
    input  logic [4:0]       lsr_rx,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             timeout_pend,
    input  logic             thr_pend,
    input  logic [3:0]       msr_delta,
    output iid_e             code
);

    logic c_line, c_tmo, c_rx, c_thr, c_mdm;

    always_comb begin
        c_line = ier[EN_LINE] && (|lsr_rx[LS_BI:LS_OE]);
        c_tmo  = ier[EN_RX] && timeout_pend;
        c_rx   = ier[EN_RX] && lsr_rx[LS_DR] && (!fifo_en || (rx_count >= rx_trig));
        c_thr  = ier[EN_THR] && thr_pend;
        c_mdm  = ier[EN_MDM] && (|msr_delta);

        if (c_line)      code = IID_LINE;
        else if (c_tmo)  code = IID_TMO;
        else if (c_rx)   code = IID_RXDATA;
        else if (c_thr)  code = IID_THR;
        else if (c_mdm)  code = IID_MODEM;
        else             code = IID_NONE;
    end

    // R2: an enabled error status always takes the top slot
    always_comb begin
        if (ier[EN_LINE] && (|lsr_rx[LS_BI:LS_OE]))
            a_r2_line_first: assert (code == IID_LINE);
    end

    // R3: with receive enable off neither receive code may appear
    always_comb begin
        if (!ier[EN_RX])
            a_r3_rx_masked: assert (code != IID_TMO && code != IID_RXDATA);
    end

endmodule

// File: rtl/uart_irq_resolver.sv
`timescale 1ns/1ps
module uart_irq_resolver
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       rd_data,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             timeout_pend,
    input  logic [3:0]       msr_delta,
    input  logic             rx_push,
    input  logic             rx_brk,
    input  logic             rx_ovr,
    input  logic             rx_par,
    input  logic             rx_frm,
    input  logic             rx_drained,
    input  logic             thr_wr,
    input  logic             thr_drained,
    input  logic             tx_idle,
    output logic [7:0]       iir,
    output logic             irq
);

    logic [7:0] lsr_q;
    logic [3:0] ier_q;
    logic       thr_pend;
    logic       ier_wr, lsr_rd, iir_ack;
    logic       unused_wdata_hi;
    iid_e       code;

    assign unused_wdata_hi = ^reg_wdata[7:4];
    assign ier_wr  = reg_wr && (reg_addr == ADDR_IER);
    assign lsr_rd  = reg_rd && (reg_addr == ADDR_LSR);
    assign iir_ack = reg_rd && (reg_addr == ADDR_IIR) && (code == IID_THR);

    uart_irq_lsr u_lsr (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_push     (rx_push),
        .rx_brk      (rx_brk),
        .rx_ovr      (rx_ovr),
        .rx_par      (rx_par),
        .rx_frm      (rx_frm),
        .rx_drained  (rx_drained),
        .thr_wr      (thr_wr),
        .thr_drained (thr_drained),
        .tx_idle     (tx_idle),
        .lsr_rd      (lsr_rd),
        .lsr_q       (lsr_q)
    );

    uart_irq_thr_fsm u_thr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ier_wr      (ier_wr),
        .ier_wdata   (reg_wdata[3:0]),
        .thr_wr      (thr_wr),
        .thr_drained (thr_drained),
        .thre        (lsr_q[LS_THRE]),
        .iir_ack     (iir_ack),
        .ier_q       (ier_q),
        .thr_pend    (thr_pend)
    );

    uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
        .ier          (ier_q),
        .lsr_rx       (lsr_q[4:0]),
        .fifo_en      (fifo_en),
        .rx_count     (rx_count),
        .rx_trig      (rx_trig),
        .timeout_pend (timeout_pend),
        .thr_pend     (thr_pend),
        .msr_delta    (msr_delta),
        .code         (code)
    );

    always_comb begin
        iir = {fifo_en, fifo_en, 2'b00, code};
        irq = (code != IID_NONE);
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_IER: rd_data = {4'h0, ier_q};
            ADDR_IIR: rd_data = iir;
            ADDR_LSR: rd_data = lsr_q;
            default:  rd_data = 8'h00;
        endcase
    end

endmodule

// File: tb/uart_irq_resolver_tb_top.sv
`timescale 1ns/1ps
module uart_irq_resolver_tb_top;

    localparam int CNT_W = 5;

    typedef struct {
        int         kind;   // 1: read data, 2: irq line
        logic [7:0] val;
        string      req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 0, reg_rd = 0;
    logic [2:0]       reg_addr = 0;
    logic [7:0]       reg_wdata = 0;
    logic [7:0]       rd_data;
    logic             fifo_en = 0;
    logic [CNT_W-1:0] rx_count = 0;
    logic [CNT_W-1:0] rx_trig = 1;
    logic             timeout_pend = 0;
    logic [3:0]       msr_delta = 0;
    logic             rx_push = 0, rx_brk = 0, rx_ovr = 0, rx_par = 0, rx_frm = 0, rx_drained = 0;
    logic             thr_wr = 0, thr_drained = 0, tx_idle = 0;
    logic [7:0]       iir;
    logic             irq;

    exp_t q[$];
    int   probe_kind = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    uart_irq_resolver #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data),
        .fifo_en(fifo_en), .rx_count(rx_count), .rx_trig(rx_trig),
        .timeout_pend(timeout_pend), .msr_delta(msr_delta),
        .rx_push(rx_push), .rx_brk(rx_brk), .rx_ovr(rx_ovr), .rx_par(rx_par),
        .rx_frm(rx_frm), .rx_drained(rx_drained), .thr_wr(thr_wr),
        .thr_drained(thr_drained), .tx_idle(tx_idle), .iir(iir), .irq(irq)
    );

    // monitor: pops one expectation per probed cycle, mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (probe_kind != 0 && q.size() > 0) begin
                exp_t e;
                logic [7:0] got;
                e = q.pop_front();
                got = (e.kind == 1) ? rd_data : {7'h0, irq};
                n_chk++;
                if (got !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: got %02h expected %02h", e.req, got, e.val);
                end
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; probe_kind = 0;
        rx_push = 0; rx_brk = 0; rx_ovr = 0; rx_par = 0; rx_frm = 0; rx_drained = 0;
        thr_wr = 0; thr_drained = 0; tx_idle = 0;
    endtask

    // driver: probe in the current cycle
    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string r);
        reg_rd = 1; reg_addr = a;
        q.push_back('{1, e, r});
        probe_kind = 1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string r);
        cyc(); rd_chk(a, e, r);
    endtask

    task automatic irq_chk(input logic e, input string r);
        cyc();
        q.push_back('{2, {7'h0, e}, r});
        probe_kind = 2;
    endtask

    task automatic wr_ier(input logic [7:0] v);
        cyc(); reg_wr = 1; reg_addr = 3'd1; reg_wdata = v;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        rd(3'd1, 8'h00, "R10");
        rd(3'd2, 8'h01, "R10");
        rd(3'd5, 8'h60, "R10");
        irq_chk(1'b0, "R10");
        // R8 enable write masks high bits; R6 rearm from reset
        wr_ier(8'hFF);
        rd(3'd1, 8'h0F, "R8");
        irq_chk(1'b1, "R6");
        rd(3'd2, 8'h02, "R5");
        irq_chk(1'b0, "R5");
        rd(3'd2, 8'h01, "R5");
        // R6 toggle off then on
        wr_ier(8'h0D);
        wr_ier(8'h0F);
        rd(3'd2, 8'h02, "R6");
        // R11 transmit status
        cyc(); thr_wr = 1;
        rd(3'd5, 8'h00, "R11");
        cyc(); thr_drained = 1;
        rd(3'd5, 8'h20, "R11");
        rd(3'd2, 8'h02, "R11");
        cyc(); tx_idle = 1;
        rd(3'd5, 8'h60, "R11");
        // R4 without FIFO
        cyc(); rx_push = 1;
        rd(3'd2, 8'h04, "R4");
        cyc(); rx_drained = 1;
        rd(3'd2, 8'h01, "R4");
        // R4 / R9 FIFO mode below and at trigger
        cyc(); fifo_en = 1; rx_trig = 4; rx_count = 3; rx_push = 1;
        rd(3'd2, 8'hC1, "R4");
        cyc(); rx_count = 4; rd_chk(3'd2, 8'hC4, "R12");
        // R3 timeout above receive data, masked by enable bit 0
        cyc(); timeout_pend = 1; rd_chk(3'd2, 8'hCC, "R12");
        rd(3'd2, 8'hCC, "R3");
        wr_ier(8'h0E);
        rd(3'd2, 8'hC1, "R3");
        wr_ier(8'h0F);
        // R2 line status tops everything; R7 parity kept on read
        cyc(); rx_par = 1;
        rd(3'd2, 8'hC6, "R2");
        rd(3'd5, 8'h65, "R7");
        rd(3'd5, 8'h65, "R7");
        cyc(); rx_drained = 1;
        rd(3'd5, 8'h60, "R7");
        rd(3'd2, 8'hCC, "R1");
        cyc(); timeout_pend = 0;
        // R7 break and overrun cleared by read
        cyc(); rx_ovr = 1; rx_brk = 1;
        irq_chk(1'b1, "R2");
        rd(3'd5, 8'h73, "R7");
        rd(3'd5, 8'h61, "R7");
        rd(3'd2, 8'hC4, "R1");
        cyc(); rx_drained = 1; rx_count = 0;
        // R1 modem lowest, transmit above it; R9 code 0 still raises irq
        cyc(); msr_delta = 4'h4;
        rd(3'd2, 8'hC0, "R1");
        irq_chk(1'b1, "R9");
        cyc(); thr_drained = 1;
        rd(3'd2, 8'hC2, "R1");
        cyc(); msr_delta = 4'h0;
        rd(3'd2, 8'hC1, "R9");
        irq_chk(1'b0, "R9");
        // R2 masked line status
        wr_ier(8'h0B);
        cyc(); rx_frm = 1;
        rd(3'd2, 8'hC1, "R2");
        rd(3'd5, 8'h68, "R2");
        cyc(); rx_drained = 1; fifo_en = 0;
        rd(3'd2, 8'h01, "R9");
        cyc(); cyc();
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", q.size());
        end
        done = 1;
        summary();
        $finish;
    end

endmodule